// File: doc/BRIEF.md
# Four-Modulus Residue-to-Binary Converter

This block turns a number held in residue form back into an ordinary unsigned binary integer. The number is given as four residues with respect to the moduli 2^N, 2^N−1, 2^(N+1)−1 and 2^(N−1)−1. Their product, M, is the dynamic range. The result is the unique integer X in [0, M) that has those four residues. The block is pure combinational logic. It has no storage, no lookup tables and no clock, so a surrounding pipeline can place registers wherever its timing requires.

Internally the block forms mixed-radix digits. The power-of-two channel gives the first digit directly. The other digits come from subtractions modulo 2^k−1 using end-around-carry adders, and from constant multiplications built as sums of bit rotations. The digits that do not depend on one another are produced side by side. A short cascade of plain binary adders then weights the digits and sums them into the output. N is a compile-time parameter. It must be even and at least 4 so that the four moduli are pairwise coprime; other values stop elaboration.

Top module: `rrc_converter`

## Requirements
- R1: For residues each below its modulus, `bin_o` equals the unique X in [0, M) with X mod 2^N = `r_even`, X mod (2^N−1) = `r_mid`, X mod (2^(N+1)−1) = `r_wide` and X mod (2^(N−1)−1) = `r_narrow`.
- R2: For any input pattern, `bin_o` is below M = 2^N·(2^N−1)·(2^(N+1)−1)·(2^(N−1)−1).
- R3: Bits N−1..0 of `bin_o` equal `r_even`.
- R4: An all-ones value on `r_mid`, `r_wide` or `r_narrow` acts exactly like zero on that channel.
- R5: The all-zero tuple converts to 0. The tuple in which every residue is its modulus minus one converts to M−1.
- R6: The output follows an input change with no clock edge in between.
- R7: When all four residues hold the same value v, with v below 2^(N−1)−1, `bin_o` equals v.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| r_even | input | N | Residue modulo 2^N |
| r_mid | input | N | Residue modulo 2^N−1 (all-ones means zero) |
| r_wide | input | N+1 | Residue modulo 2^(N+1)−1 (all-ones means zero) |
| r_narrow | input | N−1 | Residue modulo 2^(N−1)−1 (all-ones means zero) |
| bin_o | output | 4N | Reconstructed unsigned binary value |

## Verification
The bench builds two copies of the converter. One uses N=4, where M is 52080. Every integer in that range is converted, so every digit combination and every end-around carry case of the small moduli is reached. The other uses N=8, where M is about 4.2·10^9. That copy runs on random 64-bit-derived values and on directed cases that put all-ones codes on the three odd channels, and it exercises the multi-chunk folds and the larger constant inverse.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

   // Modular inverse of a modulo m by the extended Euclidean algorithm.
   // It is only called with coprime arguments at elaboration.
   function automatic longint unsigned mod_inverse(input longint unsigned a,
                                                   input longint unsigned m);
      longint t, nt, r, nr, q, tmp;
      t  = 0;
      nt = 1;
      r  = longint'(m);
      nr = longint'(a % m);
      while (nr != 0) begin
         q   = r / nr;
         tmp = t - q * nt;
         t   = nt;
         nt  = tmp;
         tmp = r - q * nr;
         r   = nr;
         nr  = tmp;
      end
      if (t < 0) t = t + longint'(m);
      return longint'(t);
   endfunction

   // Number of k-bit chunks needed to cover a w-bit operand.
   function automatic int chunk_count(input int w, input int k);
      return (w + k - 1) / k;
   endfunction

endpackage

// File: rtl/rrc_modadd.sv
// Adder modulo 2^K-1: the carry out is added back in at bit 0.
// A result of all ones stands for zero.
module rrc_modadd #(
   parameter int K = 4
) (
   input  logic [K-1:0] a,
   input  logic [K-1:0] b,
   output logic [K-1:0] y
);
   if (K < 2) begin : g_bad_width
      $error("rrc_modadd: K must be at least 2");
   end

   logic [K:0] raw_sum;

   assign raw_sum = {1'b0, a} + {1'b0, b};
   // a+b <= 2^(K+1)-2, so this second addition cannot carry out.
   assign y = raw_sum[K-1:0] + {{(K-1){1'b0}}, raw_sum[K]};
endmodule

// File: rtl/rrc_canon.sv
// Maps the redundant all-ones code of a 2^K-1 channel to zero.
module rrc_canon #(
   parameter int K = 4
) (
   input  logic [K-1:0] a,
   output logic [K-1:0] y
);
   assign y = (&a) ? '0 : a;
endmodule

// File: rtl/rrc_fold.sv
// Reduces an IN_W-bit operand modulo 2^K-1. The operand is split into
// K-bit chunks, since 2^K is congruent to 1, and the chunks are summed
// with end-around adders.
module rrc_fold #(
   parameter int IN_W = 8,
   parameter int K    = 7
) (
   input  logic [IN_W-1:0] din,
   output logic [K-1:0]    y
);
   localparam int NCH  = rrc_pkg::chunk_count(IN_W, K);
   localparam int PADW = NCH * K;

   logic [PADW-1:0] padded;
   assign padded = PADW'(din);

   if (NCH == 1) begin : g_single
      assign y = padded[K-1:0];
   end else begin : g_chain
      logic [K-1:0] acc [0:NCH-1];
      assign acc[0] = padded[K-1:0];
      for (genvar j = 1; j < NCH; j++) begin : g_chunk
         rrc_modadd #(.K(K)) add_i (
            .a (acc[j-1]),
            .b (padded[j*K +: K]),
            .y (acc[j])
         );
      end
      assign y = acc[NCH-1];
   end
endmodule

// File: rtl/rrc_cmul.sv
// Multiplication by the constant C modulo 2^K-1. Each set bit i of C
// adds a left rotation of the operand by i places.
module rrc_cmul #(
   parameter int              K = 4,
   parameter longint unsigned C = 1
) (
   input  logic [K-1:0] a,
   output logic [K-1:0] y
);
   if (K < 2 || K > 62) begin : g_bad_width
      $error("rrc_cmul: K out of range");
   end
   if (C >= ((64'd1 << K) - 64'd1)) begin : g_bad_const
      $error("rrc_cmul: constant must be reduced below 2^K-1");
   end

   logic [K-1:0] acc [0:K];
   assign acc[0] = '0;

   for (genvar i = 0; i < K; i++) begin : g_bit
      if (((C >> i) & 64'd1) == 64'd1) begin : g_term
         logic [K-1:0] rot;
         assign rot = (a << i) | (a >> (K - i));
         rrc_modadd #(.K(K)) add_i (
            .a (acc[i]),
            .b (rot),
            .y (acc[i+1])
         );
      end else begin : g_skip
         assign acc[i+1] = acc[i];
      end
   end

   assign y = acc[K];
endmodule

// File: rtl/rrc_converter.sv
// Residue-to-binary converter for the moduli
// {2^N, 2^N-1, 2^(N+1)-1, 2^(N-1)-1} by mixed-radix reconstruction.
//   X = d1 + 2^N*(d2 + (2^N-1)*(d3 + (2^(N+1)-1)*d4))
// Digit equations (all inverses reduce to rotations, except 1/6):
//   d1 = r_even
//   d2 = r_mid - d1                        mod 2^N-1
//   d3 = -4*(r_wide - d1) + 2*d2           mod 2^(N+1)-1
//   d4 = (r_narrow - d1 - 2*(d2+d3)) / 6   mod 2^(N-1)-1
module rrc_converter #(
   parameter int N = 8
) (
   input  logic [N-1:0]   r_even,
   input  logic [N-1:0]   r_mid,
   input  logic [N:0]     r_wide,
   input  logic [N-2:0]   r_narrow,
   output logic [4*N-1:0] bin_o
);
   localparam int KM = N;
   localparam int KW = N + 1;
   localparam int KN = N - 1;
   localparam int W2 = 2 * N;
   localparam int W3 = 3 * N;
   localparam longint unsigned MOD_N = (64'd1 << KN) - 64'd1;
   localparam longint unsigned INV6  = rrc_pkg::mod_inverse(64'd6, MOD_N);

   if (N < 4 || (N % 2) != 0 || N > 16) begin : g_bad_n
      $error("rrc_converter: N must be even and within 4..16");
   end

   // ---------------- digit 1 ----------------
   logic [KM-1:0] dig1;
   assign dig1 = r_even;

   // ---------------- digit 2 (mod 2^N-1) ----------------
   logic [KM-1:0] raw2, dig2;
   rrc_modadd #(.K(KM)) sub2_i (.a(r_mid), .b(~dig1), .y(raw2));
   rrc_canon  #(.K(KM)) can2_i (.a(raw2), .y(dig2));

   // ---------------- digit 3 (mod 2^(N+1)-1) ----------------
   logic [KW-1:0] diff3, neg4_3, dbl2_3, raw3, dig3;
   rrc_modadd #(.K(KW)) sub3_i (.a(r_wide), .b(~{1'b0, dig1}), .y(diff3));
   rrc_cmul   #(.K(KW), .C(64'd4)) mul4_i (.a(~diff3), .y(neg4_3));
   rrc_cmul   #(.K(KW), .C(64'd2)) mul2_i (.a({1'b0, dig2}), .y(dbl2_3));
   rrc_modadd #(.K(KW)) sum3_i (.a(neg4_3), .b(dbl2_3), .y(raw3));
   rrc_canon  #(.K(KW)) can3_i (.a(raw3), .y(dig3));

   // ---------------- digit 4 (mod 2^(N-1)-1) ----------------
   // The folds of d1 and d2 and the first subtraction run alongside the
   // digit 3 logic; only the d3 fold waits for digit 3.
   logic [KN-1:0] f1, f2, f3, part1, sum23, dbl23, part2, raw4, dig4;
   rrc_fold #(.IN_W(KM), .K(KN)) fold1_i (.din(dig1), .y(f1));
   rrc_fold #(.IN_W(KM), .K(KN)) fold2_i (.din(dig2), .y(f2));
   rrc_fold #(.IN_W(KW), .K(KN)) fold3_i (.din(dig3), .y(f3));
   rrc_modadd #(.K(KN)) sub4a_i (.a(r_narrow), .b(~f1), .y(part1));
   rrc_modadd #(.K(KN)) add23_i (.a(f2), .b(f3), .y(sum23));
   rrc_cmul   #(.K(KN), .C(64'd2)) mul2n_i (.a(sum23), .y(dbl23));
   rrc_modadd #(.K(KN)) sub4b_i (.a(part1), .b(~dbl23), .y(part2));
   rrc_cmul   #(.K(KN), .C(INV6)) inv6_i (.a(part2), .y(raw4));
   rrc_canon  #(.K(KN)) can4_i (.a(raw4), .y(dig4));

   // ---------------- weighted sum (plain adders) ----------------
   // y3 = d3 + (2^(N+1)-1)*d4 ; y2 = d2 + (2^N-1)*y3 ; X = y2*2^N + d1
   logic [W2-1:0] y3;
   logic [W3-1:0] y2;
   assign y3 = (W2'(dig4) << (N + 1)) - W2'(dig4) + W2'(dig3);
   assign y2 = (W3'(y3) << N) - W3'(y3) + W3'(dig2);
   assign bin_o = {y2, dig1};
endmodule

// File: rtl/rrc_converter_chk.sv
// Property checker attached to every rrc_converter instance.
module rrc_converter_chk #(
   parameter int N = 8
) (
   input logic [N-1:0]   r_even,
   input logic [N-1:0]   r_mid,
   input logic [N:0]     r_wide,
   input logic [N-2:0]   r_narrow,
   input logic [4*N-1:0] bin_o
);
   localparam int W = 4 * N;
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] MOD1 = ONE << N;
   localparam logic [W-1:0] MOD2 = (ONE << N) - ONE;
   localparam logic [W-1:0] MOD3 = (ONE << (N + 1)) - ONE;
   localparam logic [W-1:0] MOD4 = (ONE << (N - 1)) - ONE;
   localparam logic [W-1:0] MODP = MOD1 * MOD2 * MOD3 * MOD4;

   logic known;
   assign known = !$isunknown({r_even, r_mid, r_wide, r_narrow, bin_o});

   always_comb begin
      if (known) begin
         // R1: every channel of the output agrees with its residue
         a_r1_even_channel: assert ((bin_o % MOD1) == (W'(r_even) % MOD1))
            else $error("R1 even channel mismatch");
         a_r1_mid_channel: assert ((bin_o % MOD2) == (W'(r_mid) % MOD2))
            else $error("R1 mid channel mismatch");
         a_r1_wide_channel: assert ((bin_o % MOD3) == (W'(r_wide) % MOD3))
            else $error("R1 wide channel mismatch");
         a_r1_narrow_channel: assert ((bin_o % MOD4) == (W'(r_narrow) % MOD4))
            else $error("R1 narrow channel mismatch");
         // R2: never outside the dynamic range
         a_r2_in_range: assert (bin_o < MODP)
            else $error("R2 output beyond dynamic range");
      end
   end
endmodule

bind rrc_converter rrc_converter_chk #(.N(N)) chk_i (.*);

// File: tb/rrc_converter_tb_top.sv
`timescale 1ns/100ps
module rrc_converter_tb_top;
   localparam int NA = 4;
   localparam int NB = 8;

   localparam longint unsigned A1 = 64'd1 << NA;
   localparam longint unsigned A2 = (64'd1 << NA) - 1;
   localparam longint unsigned A3 = (64'd1 << (NA + 1)) - 1;
   localparam longint unsigned A4 = (64'd1 << (NA - 1)) - 1;
   localparam longint unsigned AM = A1 * A2 * A3 * A4;
   localparam longint unsigned B1 = 64'd1 << NB;
   localparam longint unsigned B2 = (64'd1 << NB) - 1;
   localparam longint unsigned B3 = (64'd1 << (NB + 1)) - 1;
   localparam longint unsigned B4 = (64'd1 << (NB - 1)) - 1;
   localparam longint unsigned BM = B1 * B2 * B3 * B4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [NA-1:0]   a_even, a_mid;
   logic [NA:0]     a_wide;
   logic [NA-2:0]   a_narrow;
   logic [4*NA-1:0] a_bin;
   logic [NB-1:0]   b_even, b_mid;
   logic [NB:0]     b_wide;
   logic [NB-2:0]   b_narrow;
   logic [4*NB-1:0] b_bin;

   rrc_converter #(.N(NA)) dut_i (
      .r_even(a_even), .r_mid(a_mid), .r_wide(a_wide), .r_narrow(a_narrow),
      .bin_o(a_bin));
   rrc_converter #(.N(NB)) dut_wide_i (
      .r_even(b_even), .r_mid(b_mid), .r_wide(b_wide), .r_narrow(b_narrow),
      .bin_o(b_bin));

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  done     = 1'b0;

   task automatic check(input string req, input longint unsigned act,
                        input longint unsigned exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive_a(input longint unsigned x);
      a_even   = NA'(x % A1);
      a_mid    = NA'(x % A2);
      a_wide   = (NA+1)'(x % A3);
      a_narrow = (NA-1)'(x % A4);
   endtask

   task automatic drive_b(input longint unsigned x);
      b_even   = NB'(x % B1);
      b_mid    = NB'(x % B2);
      b_wide   = (NB+1)'(x % B3);
      b_narrow = (NB-1)'(x % B4);
   endtask

   initial begin
      drive_a(0);
      drive_b(0);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R5: zero tuple after reset
      @(negedge clk);
      check("R5 zero small", longint'(a_bin), 0);
      check("R5 zero wide", longint'(b_bin), 0);

      // R5: maximum tuple
      @(posedge clk);
      drive_a(AM - 1);
      drive_b(BM - 1);
      @(negedge clk);
      check("R5 max small", longint'(a_bin), AM - 1);
      check("R5 max wide", longint'(b_bin), BM - 1);

      // R4: all-ones codes stand for zero on the odd channels
      @(posedge clk);
      drive_a(0); a_mid = '1; a_wide = '1; a_narrow = '1;
      drive_b(0); b_mid = '1; b_wide = '1; b_narrow = '1;
      @(negedge clk);
      check("R4 all-ones zero small", longint'(a_bin), 0);
      check("R4 all-ones zero wide", longint'(b_bin), 0);
      @(posedge clk);
      drive_a(105); a_mid = '1; a_narrow = '1;          // 105 = 15*7
      drive_b(32385); b_mid = '1; b_narrow = '1;        // 32385 = 255*127
      @(negedge clk);
      check("R4 mid/narrow all-ones small", longint'(a_bin), 105);
      check("R4 mid/narrow all-ones wide", longint'(b_bin), 32385);
      @(posedge clk);
      drive_a(31 * 9); a_wide = '1;
      drive_b(511 * 3); b_wide = '1;
      @(negedge clk);
      check("R4 wide all-ones small", longint'(a_bin), 31 * 9);
      check("R4 wide all-ones wide", longint'(b_bin), 511 * 3);

      // R7: equal residues below the narrow modulus
      @(posedge clk);
      drive_a(5);
      drive_b(100);
      @(negedge clk);
      check("R7 equal residues small", longint'(a_bin), 5);
      check("R7 equal residues wide", longint'(b_bin), 100);

      // R6: change inputs between edges and look before the next edge
      drive_a(40000);
      drive_b(64'd3000000000);
      #1;
      check("R6 no clock small", longint'(a_bin), 40000);
      check("R6 no clock wide", longint'(b_bin), 64'd3000000000);

      // R1/R2/R3: every value of the small range, random values on the wide one
      for (longint unsigned x = 0; x < AM; x++) begin
         longint unsigned xb;
         xb = {$urandom(), $urandom()} % BM;
         @(posedge clk);
         drive_a(x);
         drive_b(xb);
         @(negedge clk);
         check("R1 small", longint'(a_bin), x);
         check("R1 wide", longint'(b_bin), xb);
         check("R2 wide range", longint'(b_bin < 32'(BM)), 1);
         check("R3 low digit small", longint'(a_bin[NA-1:0]), x % A1);
         check("R3 low digit wide", longint'(b_bin[NB-1:0]), xb % B1);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule